// File: doc/BRIEF.md
# Width-Packing Dual-Clock FIFO

This block is a first-in first-out buffer that crosses between two unrelated clocks. It also widens the data on the way in. The producer side runs on its own write clock and presents narrow beats. A static size select picks one of two beat widths: 18-bit halves or 9-bit quarters. The block gathers the beats into 36-bit long words and stores each finished long word in a 64-entry memory. The consumer reads whole long words on the wide side, under its own clock.

Both status flags count whole long words. An active-low full flag sits in the write domain. An active-low almost-empty flag and a data-available flag sit in the read domain. A beat that does not complete a long word changes neither pointer, so it changes neither flag. Each pointer crosses to the other domain as Gray code through a two-stage synchronizer.

A read takes effect only when all of the following hold: the select is low, the direction is low, the enable is high, and data is available. The long word then lands in an output register on that read-clock edge.

Top module: `pack_cdc_fifo`

## Requirements
- R1: When `wr_byte_mode` is 0, two accepted 18-bit beats form one long word. The first beat fills bits 17:0 and the second fills bits 35:18.
- R2: When `wr_byte_mode` is 1, four accepted 9-bit beats (`wr_data[8:0]`) form one long word. Beat k fills bits 9k+8:9k, with beat 0 first.
- R3: A beat is accepted on a rising `wr_clk` edge only when `wr_en` is 1 and `wr_full_n` is 1. A beat offered while the buffer is full is dropped and changes no stored data.
- R4: `wr_full_n` goes to 0 right after the `wr_clk` edge that accepts the final beat of the 64th stored long word. Partial beats never change it.
- R5: After a read frees an entry, `wr_full_n` returns to 1 after the second `wr_clk` edge that follows that read edge.
- R6: A read occurs on a rising `rd_clk` edge only when all of these hold: `rd_sel_n` is 0, `rd_dir` is 0, `rd_en` is 1, and `rd_ready` is 1. Otherwise `rd_data` holds and no entry is consumed.
- R7: Each read loads the oldest stored long word into `rd_data`. Long words come out in the order they were completed.
- R8: `rd_ready` is 1 when the write count, as seen through the synchronizer, exceeds the number of reads. The synchronized count picks up a commit on the second `rd_clk` edge after the `wr_clk` edge that made it.
- R9: `rd_aempty_n` is 1 when the synchronized write count minus the read count exceeds `AE_LEVEL`, and 0 otherwise. It uses the same two-edge latency as R8.
- R10: While `rst_n` is 0, all of the following are cleared: both pointers, the beat counter, any partial long word, and `rd_data`. During reset `wr_full_n` is 1, `rd_ready` is 0 and `rd_aempty_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk | input | 1 | Narrow-side write clock |
| wr_en | input | 1 | Offer one beat this cycle |
| wr_byte_mode | input | 1 | Static beat size: 0 = 18-bit halves, 1 = 9-bit quarters |
| wr_data | input | 18 | Beat data (bits 8:0 only in quarter mode) |
| wr_full_n | output | 1 | Low when 64 long words are stored |
| rd_clk | input | 1 | Wide-side read clock |
| rd_sel_n | input | 1 | Active-low select of the wide side |
| rd_dir | input | 1 | Must be 0 for a read |
| rd_en | input | 1 | Read enable |
| rd_data | output | 36 | Output register holding the last long word read |
| rd_ready | output | 1 | At least one long word is available |
| rd_aempty_n | output | 1 | Low when AE_LEVEL or fewer long words are visible |

## Verification
The stimulus fills the buffer to the last entry and keeps offering beats while it is full. A design that lost the full check would overwrite unread data, and the data comparison would show corrupted long words.

One stretch of stimulus reads exactly one entry from a full buffer. This checks that the full flag clears on exactly the second write edge and not one edge early or late.

Partial long words are left behind when a reset arrives. A design that kept the stale beats would emit a shifted first word afterwards.

Read traffic also carries random select and direction values, so a design that ignored either qualifier would pop entries too early.

The quarter-mode phases catch two further faults: beats landing in the wrong lane, and a commit made after two quarters instead of four.

// File: rtl/pkf_pkg.sv
package pkf_pkg;
    localparam int LONG_W  = 36;
    localparam int WORD_W  = 18;
    localparam int BYTE_W  = 9;
    localparam int BEATS_B = LONG_W / BYTE_W;
    localparam int BEAT_W  = $clog2(BEATS_B);

    typedef enum logic {
        SIZE_HALF    = 1'b0,
        SIZE_QUARTER = 1'b1
    } beat_size_e;
endpackage

// File: rtl/pkf_sync.sv
module pkf_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pkf_store.sv
module pkf_store import pkf_pkg::*; #(
    parameter int ADDR_W = 6
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LONG_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LONG_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LONG_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pkf_wr_pack.sv
module pkf_wr_pack import pkf_pkg::*; #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              byte_mode,
    input  logic [WORD_W-1:0] din,
    input  logic [ADDR_W:0]   rgray_s,
    output logic              full,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [LONG_W-1:0] wdata,
    output logic [ADDR_W:0]   wgray
);
    typedef struct packed {
        logic [LONG_W-1:0] hold;
        logic [BEAT_W-1:0] beat;
        logic [ADDR_W:0]   ptr;
        logic [ADDR_W:0]   gray;
    } wr_state_t;

    wr_state_t         st_d, st_q;
    logic [LONG_W-1:0] merged_d;
    logic              accept_d;
    logic              last_d;

    // Full when write Gray pointer equals read Gray pointer with top two bits inverted
    assign full  = (st_q.gray == {~rgray_s[ADDR_W:ADDR_W-1], rgray_s[ADDR_W-2:0]});
    assign waddr = st_q.ptr[ADDR_W-1:0];
    assign wdata = merged_d;
    assign wgray = st_q.gray;

    always_comb begin
        st_d     = st_q;
        merged_d = st_q.hold;
        we       = 1'b0;
        accept_d = en && !full;
        if (beat_size_e'(byte_mode) == SIZE_QUARTER) begin
            last_d = (st_q.beat == BEAT_W'(BEATS_B - 1));
            merged_d[int'(st_q.beat)*BYTE_W +: BYTE_W] = din[BYTE_W-1:0];
        end else begin
            last_d = st_q.beat[0];
            merged_d[int'(st_q.beat[0])*WORD_W +: WORD_W] = din;
        end
        if (accept_d) begin
            if (last_d) begin
                we        = 1'b1;
                st_d.hold = '0;
                st_d.beat = '0;
                st_d.ptr  = st_q.ptr + 1'b1;
            end else begin
                st_d.hold = merged_d;
                st_d.beat = st_q.beat + 1'b1;
            end
        end
        st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: nothing advances while full
    a_r3_frozen_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> ($stable(st_q.ptr) && $stable(st_q.beat)));

    // R4: full can only appear after a committing edge
    a_r4_full_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(we));

    // R1: half mode never uses more than two beat positions
    a_r1_half_beat_range: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_mode |-> (st_q.beat < BEAT_W'(2)));
endmodule

// File: rtl/pkf_rd_port.sv
module pkf_rd_port import pkf_pkg::*; #(
    parameter int ADDR_W   = 6,
    parameter int AE_LEVEL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              dir,
    input  logic              en,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic [LONG_W-1:0] mem_q,
    output logic [ADDR_W-1:0] raddr,
    output logic [LONG_W-1:0] dout,
    output logic              ready,
    output logic              aempty_n,
    output logic [ADDR_W:0]   rgray
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [LONG_W-1:0] data;
        logic [ADDR_W:0]   ptr;
        logic [ADDR_W:0]   gray;
    } rd_state_t;

    rd_state_t       st_d, st_q;
    logic [ADDR_W:0] wbin_d;
    logic [ADDR_W:0] level_d;
    logic            go_d;

    always_comb begin
        wbin_d[ADDR_W] = wgray_s[ADDR_W];
        for (int i = ADDR_W - 1; i >= 0; i--) begin
            wbin_d[i] = wbin_d[i+1] ^ wgray_s[i];
        end
        level_d  = wbin_d - st_q.ptr;
        ready    = (wgray_s != st_q.gray);
        aempty_n = (int'(level_d) > AE_LEVEL);
        go_d     = !sel_n && !dir && en && ready;
        st_d     = st_q;
        if (go_d) begin
            st_d.data = mem_q;
            st_d.ptr  = st_q.ptr + 1'b1;
        end
        st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr = st_q.ptr[ADDR_W-1:0];
    assign dout  = st_q.data;
    assign rgray = st_q.gray;

    // R6: no entry consumed while nothing is visible
    a_r6_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(st_q.ptr));

    // R6: output register holds without a qualified read
    a_r6_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sel_n && !dir && en) |=> $stable(st_q.data));

    // R9: visible level never exceeds the depth
    a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level_d) <= DEPTH);

    // R8: almost-empty released implies data available
    a_r8_ae_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
        aempty_n |-> ready);
endmodule

// File: rtl/pack_cdc_fifo.sv
module pack_cdc_fifo import pkf_pkg::*; #(
    parameter int ADDR_W   = 6,
    parameter int AE_LEVEL = 2
) (
    input  logic              rst_n,
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic              wr_byte_mode,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_full_n,
    input  logic              rd_clk,
    input  logic              rd_sel_n,
    input  logic              rd_dir,
    input  logic              rd_en,
    output logic [LONG_W-1:0] rd_data,
    output logic              rd_ready,
    output logic              rd_aempty_n
);
    logic              full;
    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [LONG_W-1:0] wdata;
    logic [LONG_W-1:0] mem_q;
    logic [ADDR_W:0]   wgray;
    logic [ADDR_W:0]   rgray;
    logic [ADDR_W:0]   wgray_s;
    logic [ADDR_W:0]   rgray_s;

    pkf_wr_pack #(.ADDR_W(ADDR_W)) u_wr (
        .clk      (wr_clk),
        .rst_n    (rst_n),
        .en       (wr_en),
        .byte_mode(wr_byte_mode),
        .din      (wr_data),
        .rgray_s  (rgray_s),
        .full     (full),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata),
        .wgray    (wgray)
    );

    pkf_store #(.ADDR_W(ADDR_W)) u_mem (
        .wclk (wr_clk),
        .we   (we),
        .waddr(waddr),
        .wdata(wdata),
        .raddr(raddr),
        .rdata(mem_q)
    );

    pkf_sync #(.W(ADDR_W + 1)) u_w2r (
        .clk  (rd_clk),
        .rst_n(rst_n),
        .d    (wgray),
        .q    (wgray_s)
    );

    pkf_sync #(.W(ADDR_W + 1)) u_r2w (
        .clk  (wr_clk),
        .rst_n(rst_n),
        .d    (rgray),
        .q    (rgray_s)
    );

    pkf_rd_port #(.ADDR_W(ADDR_W), .AE_LEVEL(AE_LEVEL)) u_rd (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .sel_n   (rd_sel_n),
        .dir     (rd_dir),
        .en      (rd_en),
        .wgray_s (wgray_s),
        .mem_q   (mem_q),
        .raddr   (raddr),
        .dout    (rd_data),
        .ready   (rd_ready),
        .aempty_n(rd_aempty_n),
        .rgray   (rgray)
    );

    assign wr_full_n = !full;
endmodule

// File: tb/pack_cdc_fifo_bench.sv
module pack_cdc_fifo_bench;
    localparam int AE    = 2;
    localparam int DEPTH = 64;

    logic        rst_n = 1'b0;
    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_byte_mode = 1'b0;
    logic [17:0] wr_data = '0;
    logic        rd_sel_n = 1'b1;
    logic        rd_dir = 1'b1;
    logic        rd_en = 1'b0;
    logic        wr_full_n;
    logic [35:0] rd_data;
    logic        rd_ready;
    logic        rd_aempty_n;

    int checks = 0;
    int errors = 0;
    int rd_rate = 0;
    bit rd_junk = 0;
    bit done = 0;

    pack_cdc_fifo #(.ADDR_W(6), .AE_LEVEL(AE)) u_pack_cdc_fifo (
        .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_byte_mode(wr_byte_mode),
        .wr_data(wr_data), .wr_full_n(wr_full_n), .rd_clk(rd_clk), .rd_sel_n(rd_sel_n),
        .rd_dir(rd_dir), .rd_en(rd_en), .rd_data(rd_data), .rd_ready(rd_ready),
        .rd_aempty_n(rd_aempty_n)
    );

    // 125 MHz on both sides, read clock shifted by 3 ns
    initial forever #4 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #4 rd_clk = ~rd_clk;
    end

    // Behavioural reference model
    int          wtotal, rtotal, rs1, rs2, wq1, wq2, mbeat;
    logic [35:0] mhold;
    logic [35:0] stored[$];
    logic        full_e, ready_e, ae_e;
    logic [35:0] data_e;

    always @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wtotal = 0; rs1 = 0; rs2 = 0; mbeat = 0; mhold = '0;
            full_e = 1'b0;
            stored.delete();
        end else begin
            if (wr_en && !full_e) begin
                if (wr_byte_mode) mhold[mbeat*9 +: 9] = wr_data[8:0];
                else              mhold[mbeat*18 +: 18] = wr_data;
                mbeat++;
                if (mbeat == (wr_byte_mode ? 4 : 2)) begin
                    stored.push_back(mhold);
                    wtotal++;
                    mhold = '0;
                    mbeat = 0;
                end
            end
            rs2 = rs1;
            rs1 = rtotal;
            full_e = ((wtotal - rs2) == DEPTH);
        end
    end

    always @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rtotal = 0; wq1 = 0; wq2 = 0;
            ready_e = 1'b0; ae_e = 1'b0; data_e = '0;
        end else begin
            if (!rd_sel_n && !rd_dir && rd_en && ready_e) begin
                data_e = stored.pop_front();
                rtotal++;
            end
            wq2 = wq1;
            wq1 = wtotal;
            ready_e = (wq2 != rtotal);
            ae_e = ((wq2 - rtotal) > AE);
        end
    end

    task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge wr_clk) begin
        if (!done) begin
            if (!rst_n) chk("R10 full_n", 36'(wr_full_n), 36'(1'b1));
            else        chk("R3 R4 R5 full_n", 36'(wr_full_n), 36'(!full_e));
        end
    end

    always @(negedge rd_clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk("R10 rd_data", rd_data, '0);
                chk("R10 ready", 36'(rd_ready), 36'(1'b0));
                chk("R10 aempty_n", 36'(rd_aempty_n), 36'(1'b0));
            end else begin
                chk(wr_byte_mode ? "R2 R6 R7 rd_data" : "R1 R6 R7 rd_data", rd_data, data_e);
                chk("R8 ready", 36'(rd_ready), 36'(ready_e));
                chk("R9 aempty_n", 36'(rd_aempty_n), 36'(ae_e));
            end
        end
    end

    // Read-side driver
    always @(negedge rd_clk) begin
        rd_en    = (int'($urandom % 100) < rd_rate);
        rd_sel_n = rd_junk ? 1'($urandom) : 1'b0;
        rd_dir   = rd_junk ? 1'($urandom) : 1'b0;
    end

    task automatic do_reset(bit mode);
        @(negedge wr_clk);
        #1 rst_n = 1'b0;
        wr_byte_mode = mode;
        wr_en = 1'b0;
        repeat (3) @(negedge wr_clk);
        #2 rst_n = 1'b1;
    endtask

    task automatic wr_cycles(int n, int rate);
        repeat (n) begin
            @(negedge wr_clk);
            wr_en   = (int'($urandom % 100) < rate);
            wr_data = 18'($urandom);
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        rd_rate = 100;
        rd_junk = 0;
        repeat (200) @(negedge wr_clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        errors++;
        $display("FAIL R8 watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Half-beat packing, then junk-qualified reads (R1, R6)
        do_reset(1'b0);
        rd_rate = 0;
        wr_cycles(20, 100);
        repeat (10) @(negedge wr_clk);
        rd_rate = 100; rd_junk = 1;
        repeat (100) @(negedge wr_clk);
        drain();
        // Fill past full, free one entry, refill (R3, R4, R5)
        rd_rate = 0;
        wr_cycles(200, 100);
        repeat (10) @(negedge wr_clk);
        rd_rate = 100;
        @(negedge wr_clk);
        rd_rate = 0;
        wr_cycles(20, 100);
        drain();
        // Quarter-beat packing with mixed traffic (R2)
        do_reset(1'b1);
        rd_rate = 40; rd_junk = 1;
        wr_cycles(3000, 70);
        drain();
        rd_rate = 0;
        wr_cycles(400, 100);
        rd_rate = 30;
        wr_cycles(2000, 90);
        drain();
        // Partial long word discarded by reset (R10)
        rd_rate = 0;
        wr_cycles(2, 100);
        do_reset(1'b0);
        rd_rate = 50;
        wr_cycles(1000, 60);
        drain();
        finish_run();
    end
endmodule